// File: doc/BRIEF.md
# Block-Write Pixel Fill Unit

This unit is the masked write path of a two-bank, 32-bit-wide graphics memory model. It keeps one 32-bit fill color register and one 32-bit plane-enable register, and both banks use the same pair. It merges each write into a small internal storage array, one word per column, and drives per-column write enables that show which columns of the addressed group the current write touches.

There are two kinds of write. A normal write stores the supplied data into one column. The four byte-lane enables and the plane-enable register decide which bits actually change. A block write ignores the data word as data. It uses the low eight data bits as pixel enables for an aligned group of eight columns, and it writes the fill color into every enabled column in one cycle, so up to 256 bits move at once. The same lane and plane limits apply. A single load strobe for each register, sharing one value bus, stands in for the special-register load commands.

Top module: `pixel_fill_writer`

## Requirements
- R1: After reset every stored word is zero, the fill color is zero and the plane-enable register is all ones, so a first normal write with all lanes enabled stores its data unchanged.
- R2: A normal write to column c changes stored bit b of word c only when byte lane b/8 is enabled (wrByteEn bit b/8 = 1) and plane-enable bit b is 1. Every other bit keeps its old value.
- R3: A block write addresses columns g to g+7, where g is wrCol with its three low bits forced to zero. Column g+i is written with the fill color only when wrData bit i is 1. wrData bits 31 to 8 have no effect.
- R4: loadColor captures loadValue at the clock edge. A write issued in the same cycle as the load still uses the previous color. Writes in later cycles use the new one.
- R5: loadMask captures loadValue into the plane-enable register with the same timing as R4. Both banks use that single register.
- R6: The byte-lane enables and the plane-enable register limit block writes exactly as they limit normal writes.
- R7: A write changes only the bank chosen by wrBank (0 or 1). The other bank stays untouched.
- R8: colWe is zero when wrValid is low. For a normal write it has exactly one bit set, at position wrCol[2:0]. For a block write it equals wrData[7:0].
- R9: rdData shows, without a clock, the stored word at bank rdBank and column rdCol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadColor | input | 1 | Load fill color from loadValue |
| loadMask | input | 1 | Load plane-enable register from loadValue |
| loadValue | input | 32 | Value for register loads |
| wrValid | input | 1 | Write request this cycle |
| wrBlock | input | 1 | 1 = block write, 0 = normal write |
| wrBank | input | 1 | Bank select |
| wrCol | input | 5 | Column address |
| wrData | input | 32 | Write data, or pixel enables in bits 7..0 for a block write |
| wrByteEn | input | 4 | Byte-lane enables, bit k covers data bits 8k+7..8k |
| rdBank | input | 1 | Read bank select |
| rdCol | input | 5 | Read column address |
| rdData | output | 32 | Stored word at rdBank/rdCol |
| colWe | output | 8 | Per-column write enables within the addressed 8-column group |

## Verification
The bench targets several boundaries. A block write whose column address has nonzero low bits must land on the aligned group; a unit that skipped the alignment would smear color across two groups. A load in the same cycle as a write must not reach that write; a bypassed register would put the new color into the older write. A block write with only high data bits set must change nothing, and a unit that read the wrong enable bits would write columns. Partial lane and plane masks must leave the masked bits holding old data rather than zeros, and the unselected bank must survive every operation, which catches a merge that drops the old word or a bank decode that writes both banks.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  localparam int PIX_W   = 32;
  localparam int LANES   = PIX_W / 8;
  localparam int GROUP_N = 8;
  localparam int GRP_W   = $clog2(GROUP_N);

  // strobes passed from control to datapath
  typedef struct packed {
    logic               wrEn;
    logic               useColor;
    logic [GROUP_N-1:0] colSel;
    logic [LANES-1:0]   laneEn;
  } wrStrobe_t;
endpackage

// File: rtl/pfw_control.sv
module pfw_control
  import pfw_pkg::*;
#(
  parameter int COL_W = 5
) (
  input  logic               wrValid,
  input  logic               wrBlock,
  input  logic [COL_W-1:0]   wrCol,
  input  logic [GROUP_N-1:0] pixEn,
  input  logic [LANES-1:0]   wrByteEn,
  output wrStrobe_t          strobe
);
  logic [GROUP_N-1:0] oneCol;

  always_comb begin
    oneCol = '0;
    oneCol[wrCol[GRP_W-1:0]] = 1'b1;
  end

  always_comb begin
    strobe.wrEn     = wrValid;
    strobe.useColor = wrValid & wrBlock;
    strobe.laneEn   = wrByteEn;
    if (!wrValid)
      strobe.colSel = '0;
    else if (wrBlock)
      strobe.colSel = pixEn;
    else
      strobe.colSel = oneCol;
  end
endmodule

// File: rtl/pfw_datapath.sv
module pfw_datapath
  import pfw_pkg::*;
#(
  parameter int COLS  = 32,
  parameter int BANKS = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     loadColor,
  input  logic                     loadMask,
  input  logic [PIX_W-1:0]         loadValue,
  input  wrStrobe_t                strobe,
  input  logic [$clog2(BANKS)-1:0] wrBank,
  input  logic [$clog2(COLS)-1:0]  wrCol,
  input  logic [PIX_W-1:0]         wrData,
  input  logic [$clog2(BANKS)-1:0] rdBank,
  input  logic [$clog2(COLS)-1:0]  rdCol,
  output logic [PIX_W-1:0]         rdData,
  output logic [PIX_W-1:0]         colorQ,
  output logic [PIX_W-1:0]         maskQ
);
  localparam int COL_W = $clog2(COLS);
  localparam int BASE_W = COL_W - GRP_W;

  logic [PIX_W-1:0]  mem [BANKS][COLS];
  logic [PIX_W-1:0]  laneBits;
  logic [PIX_W-1:0]  bitEn;
  logic [PIX_W-1:0]  srcWord;
  logic [BASE_W-1:0] grpBase;

  genvar gb;
  generate
    for (gb = 0; gb < PIX_W; gb++) begin : g_lane
      assign laneBits[gb] = strobe.laneEn[gb / 8];
    end
  endgenerate

  assign bitEn   = laneBits & maskQ;
  assign srcWord = strobe.useColor ? colorQ : wrData;
  assign grpBase = wrCol[COL_W-1:GRP_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colorQ <= '0;
      maskQ  <= '1;
      for (int b = 0; b < BANKS; b++)
        for (int c = 0; c < COLS; c++)
          mem[b][c] <= '0;
    end else begin
      if (loadColor) colorQ <= loadValue;
      if (loadMask)  maskQ  <= loadValue;
      if (strobe.wrEn)
        for (int i = 0; i < GROUP_N; i++)
          if (strobe.colSel[i])
            mem[wrBank][{grpBase, GRP_W'(i)}] <=
              (mem[wrBank][{grpBase, GRP_W'(i)}] & ~bitEn) | (srcWord & bitEn);
    end
  end

  assign rdData = mem[rdBank][rdCol];
endmodule

// File: rtl/pixel_fill_writer.sv
module pixel_fill_writer
  import pfw_pkg::*;
#(
  parameter int COLS  = 32,
  parameter int BANKS = 2,
  localparam int COL_W  = $clog2(COLS),
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadColor,
  input  logic               loadMask,
  input  logic [PIX_W-1:0]   loadValue,
  input  logic               wrValid,
  input  logic               wrBlock,
  input  logic [BANK_W-1:0]  wrBank,
  input  logic [COL_W-1:0]   wrCol,
  input  logic [PIX_W-1:0]   wrData,
  input  logic [LANES-1:0]   wrByteEn,
  input  logic [BANK_W-1:0]  rdBank,
  input  logic [COL_W-1:0]   rdCol,
  output logic [PIX_W-1:0]   rdData,
  output logic [GROUP_N-1:0] colWe
);
  wrStrobe_t        strobe;
  logic [PIX_W-1:0] colorQ;
  logic [PIX_W-1:0] maskQ;

  pfw_control #(.COL_W(COL_W)) u_ctl (
    .wrValid (wrValid),
    .wrBlock (wrBlock),
    .wrCol   (wrCol),
    .pixEn   (wrData[GROUP_N-1:0]),
    .wrByteEn(wrByteEn),
    .strobe  (strobe)
  );

  pfw_datapath #(.COLS(COLS), .BANKS(BANKS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .loadColor(loadColor),
    .loadMask (loadMask),
    .loadValue(loadValue),
    .strobe   (strobe),
    .wrBank   (wrBank),
    .wrCol    (wrCol),
    .wrData   (wrData),
    .rdBank   (rdBank),
    .rdCol    (rdCol),
    .rdData   (rdData),
    .colorQ   (colorQ),
    .maskQ    (maskQ)
  );

  assign colWe = strobe.colSel;
endmodule

// File: rtl/pfw_checker.sv
module pfw_checker
  import pfw_pkg::*;
#(
  parameter int COL_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               loadColor,
  input logic               loadMask,
  input logic [PIX_W-1:0]   loadValue,
  input logic               wrValid,
  input logic               wrBlock,
  input logic [COL_W-1:0]   wrCol,
  input logic [PIX_W-1:0]   wrData,
  input logic [GROUP_N-1:0] colWe,
  input logic [PIX_W-1:0]   colorQ,
  input logic [PIX_W-1:0]   maskQ
);
  assert_color_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    loadColor |=> colorQ == $past(loadValue));
  assert_color_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !loadColor |=> $stable(colorQ));
  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    loadMask |=> maskQ == $past(loadValue));
  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !loadMask |=> $stable(maskQ));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |-> colWe == '0);
  assert_single_col_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrBlock) |-> ($countones(colWe) == 1 && colWe[wrCol[GRP_W-1:0]]));
  assert_block_cols_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrBlock) |-> colWe == wrData[GROUP_N-1:0]);
endmodule

bind pixel_fill_writer pfw_checker #(.COL_W(COL_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .loadColor(loadColor),
  .loadMask (loadMask),
  .loadValue(loadValue),
  .wrValid  (wrValid),
  .wrBlock  (wrBlock),
  .wrCol    (wrCol),
  .wrData   (wrData),
  .colWe    (colWe),
  .colorQ   (colorQ),
  .maskQ    (maskQ)
);

// File: tb/sim_pixel_fill_writer.sv
`timescale 1ns/1ps
module sim_pixel_fill_writer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadColor = 1'b0, loadMask = 1'b0;
  logic [31:0] loadValue = '0;
  logic        wrValid = 1'b0, wrBlock = 1'b0;
  logic        wrBank = 1'b0;
  logic [4:0]  wrCol = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  wrByteEn = '0;
  logic        rdBank = 1'b0;
  logic [4:0]  rdCol = '0;
  logic [31:0] rdData;
  logic [7:0]  colWe;

  int checks = 0;
  int fails = 0;
  logic [31:0] mdl [2][32];
  logic [31:0] mColor, mMask;

  always #2.5 clk = ~clk;

  pixel_fill_writer u0 (
    .clk(clk), .rstN(rstN), .loadColor(loadColor), .loadMask(loadMask),
    .loadValue(loadValue), .wrValid(wrValid), .wrBlock(wrBlock),
    .wrBank(wrBank), .wrCol(wrCol), .wrData(wrData), .wrByteEn(wrByteEn),
    .rdBank(rdBank), .rdCol(rdCol), .rdData(rdData), .colWe(colWe)
  );

  // {block, bank, col[4:0], byteEn[3:0], data[31:0]}
  localparam int NV = 10;
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 1'b0, 5'd2,  4'hF, 32'hDEAD_BEEF},
    {1'b0, 1'b1, 5'd2,  4'h5, 32'h1122_3344},
    {1'b1, 1'b0, 5'd13, 4'hF, 32'h0000_00A5},
    {1'b1, 1'b1, 5'd16, 4'hF, 32'h0000_00FF},
    {1'b1, 1'b0, 5'd31, 4'h6, 32'h0000_0081},
    {1'b0, 1'b0, 5'd10, 4'h8, 32'hFFFF_FFFF},
    {1'b1, 1'b1, 5'd7,  4'h1, 32'h0000_003C},
    {1'b0, 1'b1, 5'd20, 4'h0, 32'h5555_5555},
    {1'b1, 1'b0, 5'd24, 4'hC, 32'hFFFF_FF0F},
    {1'b0, 1'b0, 5'd27, 4'hA, 32'hCAFE_F00D}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] src,
                                        input logic [3:0] be, input logic [31:0] pm);
    logic [31:0] en;
    for (int b = 0; b < 32; b++) en[b] = be[b / 8] & pm[b];
    return (old & ~en) | (src & en);
  endfunction

  // one clock cycle of stimulus, the model updated after the edge
  task automatic cycleOp(input logic lc, input logic lm, input logic [31:0] lv,
                         input logic wv, input logic blk, input logic bank,
                         input logic [4:0] col, input logic [31:0] data, input logic [3:0] be);
    logic [7:0] expWe;
    logic [4:0] base;
    @(negedge clk);
    loadColor = lc; loadMask = lm; loadValue = lv;
    wrValid = wv; wrBlock = blk; wrBank = bank; wrCol = col; wrData = data; wrByteEn = be;
    #1;
    if (!wv) expWe = 8'h00;
    else if (blk) expWe = data[7:0];
    else expWe = 8'h01 << col[2:0];
    check("R8 colWe", {24'h0, colWe}, {24'h0, expWe});
    @(posedge clk);
    #1;
    loadColor = 1'b0; loadMask = 1'b0; wrValid = 1'b0;
    if (wv) begin
      base = {col[4:3], 3'b000};
      if (blk) begin
        for (int i = 0; i < 8; i++)
          if (data[i]) mdl[bank][base + i] = merge(mdl[bank][base + i], mColor, be, mMask);
      end else
        mdl[bank][col] = merge(mdl[bank][col], data, be, mMask);
    end
    if (lc) mColor = lv;
    if (lm) mMask = lv;
  endtask

  task automatic checkWord(input string req, input logic bank, input logic [4:0] col);
    @(negedge clk);
    rdBank = bank; rdCol = col;
    #1;
    check(req, rdData, mdl[bank][col]);
  endtask

  task automatic checkGroup(input string req, input logic bank, input logic [4:0] col);
    for (int i = 0; i < 8; i++) checkWord(req, bank, {col[4:3], 3'(i)});
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int c = 0; c < 32; c++) mdl[b][c] = '0;
    mColor = '0; mMask = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset contents
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 32; c++) checkWord("R1 reset word", b[0], 5'(c));
    // R1: default plane-enable is all ones
    cycleOp(0, 0, 0, 1, 0, 0, 5'd3, 32'h1234_5678, 4'hF);
    checkWord("R1 default mask", 0, 5'd3);
    check("R1 default mask value", mdl[0][3], 32'h1234_5678);

    // table walk with a fill color loaded and a partial plane mask
    cycleOp(1, 1, 32'hA5C3_0F96, 0, 0, 0, 0, 0, 0);
    for (int v = 0; v < NV; v++) begin
      logic [42:0] e;
      e = VEC[v];
      if (v == 5) cycleOp(0, 1, 32'hF0F0_FF00, 0, 0, 0, 0, 0, 0);
      cycleOp(0, 0, 0, 1, e[42], e[41], e[40:36], e[31:0], e[35:32]);
      checkGroup("R2/R3/R6 table group", e[41], e[40:36]);
      checkGroup("R7 other bank", ~e[41], e[40:36]);
    end

    // R4: same-cycle color load does not reach the write
    cycleOp(0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    cycleOp(1, 0, 32'h0BAD_CAFE, 1, 1, 1, 5'd9, 32'h0000_0003, 4'hF);
    checkWord("R4 old color used", 1, 5'd8);
    check("R4 old color value", mdl[1][8], 32'hA5C3_0F96);
    cycleOp(0, 0, 0, 1, 1, 1, 5'd9, 32'h0000_0002, 4'hF);
    checkWord("R4 new color used", 1, 5'd9);
    check("R4 new color value", mdl[1][9], 32'h0BAD_CAFE);

    // R5: plane mask shared by both banks, same-cycle timing
    cycleOp(0, 1, 32'h0000_FFFF, 1, 0, 1, 5'd30, 32'hFFFF_FFFF, 4'hF);
    checkWord("R5 old mask used", 1, 5'd30);
    cycleOp(0, 0, 0, 1, 0, 1, 5'd29, 32'h0000_0000, 4'hF);
    checkWord("R5 mask bank1", 1, 5'd29);
    cycleOp(0, 0, 0, 1, 1, 0, 5'd0, 32'h0000_00FF, 4'hF);
    checkGroup("R5 mask bank0 block", 0, 5'd0);

    // R3: high data bits have no effect on a block write
    cycleOp(0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    cycleOp(0, 0, 0, 1, 1, 1, 5'd22, 32'hFFFF_FF00, 4'hF);
    checkGroup("R3 high bits ignored", 1, 5'd16);

    // random mix, then full compare
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r;
      r = $urandom;
      cycleOp(r[0] & r[1], r[2] & r[3], $urandom, r[4] | r[5], r[6], r[7],
              r[12:8], $urandom, r[16:13]);
    end
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 32; c++) checkWord("R2/R3/R7 random compare", b[0], 5'(c));

    // R9: read port follows address without a clock
    rdBank = 1'b0; rdCol = 5'd3;
    #1; check("R9 read addr a", rdData, mdl[0][3]);
    rdBank = 1'b1; rdCol = 5'd9;
    #1; check("R9 read addr b", rdData, mdl[1][9]);

    finishRun();
  end
endmodule